// File: doc/BRIEF.md
# Refresh-Hiding Banked Memory Controller

This block puts a static-memory face on a banked dynamic array. A client issues single-cycle reads and writes on a plain synchronous port. The data of a read shows up on the following cycle, with no wait state and no handshake. Behind the port, the storage is split into several banks, and each bank holds a number of rows of several words. An internal sequencer must visit every row of every bank within a fixed deadline.

To keep refresh invisible, the controller holds one cache block exactly as large as one bank. The cache always moves toward the bank that holds the next row due for refresh. When the client touches that bank, the access goes to the cache if possible. The first touch of a row copies that row into the cache. After that the bank's own port stays free for the refresh in the same cycle. Rows changed in the cache are marked dirty and written back to their home bank on a cycle when that bank is idle. The cache is cleared and handed to the next bank only after every dirty row has been written back. Because each row can miss into the cache only once, a refresh can be held off for at most about two bank-lengths of cycles. This is shorter than one refresh period.

Top module: `refhide_mem`

## Requirements
- R1: A read request returns, on `rdata` one cycle later, the most recent value written to that address, for any mix and order of accesses, with no wait state.
- R2: The address splits as {bank, row, column}: the column is the lowest `$clog2(NCOLS)` bits, the row the next `$clog2(NROWS)` bits, and the bank the highest `$clog2(NBANKS)` bits. Every bank, row and column holds its own independent word.
- R3: The refresh sequencer produces one refresh request every REF_PERIOD cycles. It serves the requests in round-robin order: all rows of a bank in increasing order, then the next bank. With an idle port, `refresh_miss` stays 0.
- R4: Even when every access targets a single bank, including a pattern that leaves some of its rows untouched, no row goes longer than (NBANKS*NROWS+1)*REF_PERIOD + 4*NROWS cycles without a refresh. At most one refresh request is ever outstanding.
- R5: An access that hits a valid row of the cached bank leaves that bank's own port free, so a pending refresh of that bank completes in the same cycle.
- R6: A dirty cached row is never lost. The cache is retargeted to a new bank only when no row is dirty, and a dirty row is always also valid.
- R7: After reset, `rdata` is 0 and `refresh_miss` is 0.
- R8: `rdata` changes only after a read request. Write requests and idle cycles leave it holding its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request this cycle |
| we | input | 1 | 1 = write, 0 = read (when req is 1) |
| addr | input | log2(NBANKS)+log2(NROWS)+log2(NCOLS) | Word address {bank, row, column} |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, valid the cycle after a read request |
| refresh_miss | output | 1 | Sticky: some row exceeded its refresh deadline |

## Verification
On every cycle, the assertions check four things: the refresh pointer steps by exactly one row per completed refresh, at most one refresh request is outstanding, no row ever passes its deadline, and dirty rows are always valid and never dropped by a cache retarget. Whether the data stays coherent across cache fills, write-backs and bank switches can only be shown by the bench. Its scenarios cover a full sweep of every address, random mixed traffic, and long runs that hammer one bank, including runs that touch only two of its rows. Every read is compared against an independent reference memory.

// File: rtl/refhide_pkg.sv
package refhide_pkg;
  // Longest tolerated gap between two refreshes of one row, in cycles.
  // One full sweep plus one period of queueing plus the worst hold-off
  // (write back a full bank, then fill a full bank).
  function automatic int row_deadline(input int total_rows, input int period, input int nrows);
    row_deadline = (total_rows + 1) * period + 4 * nrows;
  endfunction
endpackage

// File: rtl/refhide_seq.sv
// Refresh sequencer: periodic request, round-robin pointer, per-row age watch.
// NBANKS and NROWS must be powers of two.
module refhide_seq #(
  parameter int NBANKS     = 4,
  parameter int NROWS      = 8,
  parameter int REF_PERIOD = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fire,    // refresh performed this cycle
  output logic                      pend,    // a refresh is requested
  output logic [$clog2(NBANKS)-1:0] bank_o,  // bank of the requested row
  output logic                      miss
);
  localparam int TOTAL = NBANKS * NROWS;
  localparam int BW    = $clog2(NBANKS);
  localparam int RW    = $clog2(NROWS);
  localparam int PW    = BW + RW;
  localparam int TW    = $clog2(REF_PERIOD);
  localparam int DLINE = refhide_pkg::row_deadline(TOTAL, REF_PERIOD, NROWS);
  localparam int AGW   = $clog2(DLINE + 2);
  localparam logic [AGW-1:0] DL  = AGW'(DLINE);
  localparam logic [AGW-1:0] SAT = AGW'(DLINE + 1);

  logic [TW-1:0]  timer_q;
  logic           tick;
  logic [2:0]     owed_q;
  logic [PW-1:0]  ptr_q;
  logic [TOTAL-1:0] late;
  logic           miss_q;

  assign tick   = (timer_q == TW'(REF_PERIOD - 1));
  assign pend   = (owed_q != 3'd0);
  assign bank_o = ptr_q[PW-1 -: BW];
  assign miss   = miss_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timer_q <= '0;
      owed_q  <= '0;
      ptr_q   <= '0;
      miss_q  <= 1'b0;
    end else begin
      timer_q <= tick ? '0 : timer_q + 1'b1;
      owed_q  <= owed_q + {2'b00, tick} - {2'b00, fire};
      if (fire) ptr_q <= ptr_q + 1'b1;
      miss_q  <= miss_q | (|late);
    end
  end

  for (genvar g = 0; g < TOTAL; g++) begin : g_age
    logic [AGW-1:0] age;
    always_ff @(posedge clk) begin
      if (!rst_n)                             age <= '0;
      else if (fire && ptr_q == PW'(g))       age <= '0;
      else if (age != SAT)                    age <= age + 1'b1;
    end
    assign late[g] = (age > DL);
  end

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ptr_q == PW'($past(ptr_q) + 1'b1));
  // R3
  fire_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> pend);
  // R4
  backlog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    owed_q <= 3'd1);
  // R4
  no_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_q);
endmodule

// File: rtl/refhide_array.sv
// Behavioural banked storage: one row read port, one word write port,
// one row write-back port. The two write ports never target the same bank.
module refhide_array #(
  parameter int NBANKS = 4,
  parameter int NROWS  = 8,
  parameter int NCOLS  = 4,
  parameter int DW     = 16
) (
  input  logic                                     clk,
  input  logic [$clog2(NBANKS)+$clog2(NROWS)-1:0]  rd_idx,
  output logic [NCOLS*DW-1:0]                      rd_line,
  input  logic                                     wr_en,
  input  logic [$clog2(NBANKS)+$clog2(NROWS)-1:0]  wr_idx,
  input  logic [$clog2(NCOLS)-1:0]                 wr_col,
  input  logic [DW-1:0]                            wr_word,
  input  logic                                     wb_en,
  input  logic [$clog2(NBANKS)+$clog2(NROWS)-1:0]  wb_idx,
  input  logic [NCOLS*DW-1:0]                      wb_line
);
  localparam int TOTAL = NBANKS * NROWS;
  localparam int LW    = NCOLS * DW;

  logic [LW-1:0] mem [TOTAL];

  assign rd_line = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx][wr_col*DW +: DW] <= wr_word;
    if (wb_en) mem[wb_idx] <= wb_line;
  end
endmodule

// File: rtl/refhide_cache.sv
// One bank-sized cache block: bank tag, per-row valid and dirty, row data.
module refhide_cache #(
  parameter int NBANKS = 4,
  parameter int NROWS  = 8,
  parameter int NCOLS  = 4,
  parameter int DW     = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [$clog2(NROWS)-1:0]    rd_row,
  output logic [NCOLS*DW-1:0]         rd_line,
  input  logic [$clog2(NROWS)-1:0]    wb_row,
  output logic [NCOLS*DW-1:0]         wb_line,
  output logic [$clog2(NBANKS)-1:0]   tag,
  output logic [NROWS-1:0]            valid,
  output logic [NROWS-1:0]            dirty,
  input  logic                        u_en,     // fill or write hit
  input  logic [$clog2(NROWS)-1:0]    u_row,
  input  logic [NCOLS*DW-1:0]         u_line,
  input  logic                        u_dirty,
  input  logic                        wb_clr,   // row written back
  input  logic                        retarget,
  input  logic [$clog2(NBANKS)-1:0]   new_tag
);
  localparam int LW = NCOLS * DW;

  logic [LW-1:0] line_q [NROWS];

  assign rd_line = line_q[rd_row];
  assign wb_line = line_q[wb_row];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag   <= '0;
      valid <= '0;
      dirty <= '0;
    end else begin
      if (retarget) begin
        tag   <= new_tag;
        valid <= '0;
        dirty <= '0;
      end
      if (wb_clr) dirty[wb_row] <= 1'b0;
      // a user write in the same cycle re-marks its row dirty
      if (u_en) begin
        valid[u_row] <= 1'b1;
        if (u_dirty) dirty[u_row] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (u_en) line_q[u_row] <= u_line;
  end

  // R6
  dirty_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dirty & ~valid) == '0);
  // R6
  retarget_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tag != $past(tag)) |-> ($past(dirty) == '0));
endmodule

// File: rtl/refhide_mem.sv
// Top: user port, cache routing, refresh arbitration and write-back.
module refhide_mem #(
  parameter int NBANKS     = 4,
  parameter int NROWS      = 8,
  parameter int NCOLS      = 4,
  parameter int DW         = 16,
  parameter int REF_PERIOD = 32
) (
  input  logic                                                    clk,
  input  logic                                                    rst_n,
  input  logic                                                    req,
  input  logic                                                    we,
  input  logic [$clog2(NBANKS)+$clog2(NROWS)+$clog2(NCOLS)-1:0]   addr,
  input  logic [DW-1:0]                                           wdata,
  output logic [DW-1:0]                                           rdata,
  output logic                                                    refresh_miss
);
  localparam int BW = $clog2(NBANKS);
  localparam int RW = $clog2(NROWS);
  localparam int CW = $clog2(NCOLS);
  localparam int AW = BW + RW + CW;
  localparam int LW = NCOLS * DW;

  function automatic logic [LW-1:0] put_word(input logic [LW-1:0] l,
                                             input logic [CW-1:0] c,
                                             input logic [DW-1:0] w);
    put_word = l;
    put_word[c*DW +: DW] = w;
  endfunction

  function automatic logic [DW-1:0] get_word(input logic [LW-1:0] l,
                                             input logic [CW-1:0] c);
    get_word = l[c*DW +: DW];
  endfunction

  function automatic logic [RW-1:0] first_set(input logic [NROWS-1:0] d);
    first_set = '0;
    for (int i = NROWS - 1; i >= 0; i--) if (d[i]) first_set = RW'(i);
  endfunction

  // address fields (R2)
  logic [BW-1:0] ubank;
  logic [RW-1:0] urow;
  logic [CW-1:0] ucol;
  assign ubank = addr[AW-1 -: BW];
  assign urow  = addr[CW +: RW];
  assign ucol  = addr[CW-1:0];

  // named internal events
  logic          ref_pend, ref_fire;
  logic [BW-1:0] ref_bank;
  logic [BW-1:0] tag;
  logic [NROWS-1:0] valid, dirty;
  logic          hit, arr_use, tag_miss, on_tag;
  logic          wb_do, retarget;
  logic [RW-1:0] wb_row;
  logic [LW-1:0] c_line, c_wb_line, a_line, user_line, new_line;

  assign on_tag   = req && (ubank == tag);
  assign hit      = on_tag && valid[urow];
  assign arr_use  = req && !hit;
  assign tag_miss = on_tag && !valid[urow];
  assign ref_fire = ref_pend && !(arr_use && ubank == ref_bank);
  assign wb_row   = first_set(dirty);
  assign wb_do    = (tag != ref_bank) && (|dirty) && !(arr_use && on_tag);
  assign retarget = (tag != ref_bank) && !(|dirty) && !on_tag;

  assign user_line = hit ? c_line : a_line;
  assign new_line  = we ? put_word(user_line, ucol, wdata) : user_line;

  refhide_seq #(.NBANKS(NBANKS), .NROWS(NROWS), .REF_PERIOD(REF_PERIOD)) u_seq (
    .clk(clk), .rst_n(rst_n), .fire(ref_fire), .pend(ref_pend),
    .bank_o(ref_bank), .miss(refresh_miss)
  );

  refhide_cache #(.NBANKS(NBANKS), .NROWS(NROWS), .NCOLS(NCOLS), .DW(DW)) u_cache (
    .clk(clk), .rst_n(rst_n),
    .rd_row(urow), .rd_line(c_line),
    .wb_row(wb_row), .wb_line(c_wb_line),
    .tag(tag), .valid(valid), .dirty(dirty),
    .u_en((hit && we) || tag_miss), .u_row(urow), .u_line(new_line), .u_dirty(we),
    .wb_clr(wb_do), .retarget(retarget), .new_tag(ref_bank)
  );

  refhide_array #(.NBANKS(NBANKS), .NROWS(NROWS), .NCOLS(NCOLS), .DW(DW)) u_arr (
    .clk(clk),
    .rd_idx({ubank, urow}), .rd_line(a_line),
    .wr_en(arr_use && we && !on_tag), .wr_idx({ubank, urow}), .wr_col(ucol), .wr_word(wdata),
    .wb_en(wb_do), .wb_idx({tag, wb_row}), .wb_line(c_wb_line)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)           rdata <= '0;
    else if (req && !we)  rdata <= get_word(user_line, ucol);
  end

  // R5
  hit_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pend && hit) |-> ref_fire);
  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req && !we) |-> $stable(rdata));
endmodule

// File: tb/tb_refhide_mem.sv
module tb_refhide_mem;
  localparam int NB = 4, NR = 8, NC = 4, DW = 16, RP = 32;
  localparam int AW = 7;     // 2 bank + 3 row + 2 column bits
  localparam int NW = 128;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic refresh_miss;

  always #5 clk = ~clk;

  refhide_mem #(.NBANKS(NB), .NROWS(NR), .NCOLS(NC), .DW(DW), .REF_PERIOD(RP)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .refresh_miss(refresh_miss)
  );

  int total = 0, bad = 0;
  logic [DW-1:0] ref_mem [NW];
  logic [DW-1:0] exp_rd = '0;
  string tagname = "R7";
  bit done = 0;

  function automatic logic [AW-1:0] mk_addr(input int b, input int r, input int c);
    mk_addr = AW'(b * NR * NC + r * NC + c);
  endfunction

  task automatic check(input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  // one cycle: check the outputs left by the previous edge, then drive
  task automatic step(input bit r, input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    check(tagname, rdata, exp_rd);
    check("R4", {15'd0, refresh_miss}, 16'd0);
    req = r; we = w; addr = a; wdata = d;
    if (r && !w) exp_rd = ref_mem[a];
    if (r && w)  ref_mem[a] = d;
  endtask

  task automatic rand_op(input int b, input int rlo, input int rspan);
    int rr = rlo + int'($urandom_range(rspan - 1, 0));
    int cc = int'($urandom_range(NC - 1, 0));
    bit ww = $urandom_range(1, 0) == 1;
    step(1'b1, ww, mk_addr(b, rr, cc), DW'($urandom));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NW; i++) ref_mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R7: reset state
    tagname = "R7";
    check("R7", rdata, 16'd0);
    check("R7", {15'd0, refresh_miss}, 16'd0);

    // R2: every address gets its own value; then read all back
    tagname = "R2";
    for (int b = 0; b < NB; b++)
      for (int r = 0; r < NR; r++)
        for (int c = 0; c < NC; c++)
          step(1'b1, 1'b1, mk_addr(b, r, c), DW'(16'hA000 + b * 256 + r * 16 + c));
    for (int i = NW - 1; i >= 0; i--) step(1'b1, 1'b0, AW'(i), '0);

    // R1: random mixed traffic over all banks
    tagname = "R1";
    for (int i = 0; i < 3000; i++) rand_op(int'($urandom_range(NB - 1, 0)), 0, NR);

    // R5: hammer one bank, all rows
    tagname = "R5";
    for (int i = 0; i < 4000; i++) rand_op(2, 0, NR);

    // R4: hammer one bank, only two rows, rest never touched
    tagname = "R4";
    for (int i = 0; i < 4000; i++) rand_op(1, 3, 2);
    // writes only, one row, to keep rows dirty
    for (int i = 0; i < 2500; i++)
      step(1'b1, 1'b1, mk_addr(3, 5, i % NC), DW'(i));

    // R8: writes and idles leave rdata alone
    tagname = "R8";
    step(1'b1, 1'b0, mk_addr(0, 1, 2), '0);
    step(1'b1, 1'b1, mk_addr(0, 1, 2), 16'h5A5A);
    step(1'b0, 1'b0, '0, '0);
    step(1'b1, 1'b1, mk_addr(2, 7, 3), 16'hC3C3);
    step(1'b1, 1'b0, mk_addr(0, 1, 2), '0);

    // R3: idle port across more than a full sweep
    tagname = "R3";
    for (int i = 0; i < 1500; i++) step(1'b0, 1'b0, '0, '0);
    check("R3", {15'd0, refresh_miss}, 16'd0);

    // R6: full readback after many bank switches and write-backs
    tagname = "R6";
    for (int i = 0; i < NW; i++) step(1'b1, 1'b0, AW'(i), '0);
    step(1'b0, 1'b0, '0, '0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule